// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block protects a twisted-pair transmitter from a station whose transmit path has stuck on. It watches a transmit-active input and measures each continuous transmission in coarse ticks from a built-in prescaler. The prescaler is sized so that one tick is nominally one millisecond. When a transmission reaches the permitted length, the block cuts the driver enable, raises collision and sets a sticky status flag. It then holds the fault until transmit has been quiet for a long release interval. Only after that interval does it drop collision and give the driver back.

The watchdog works in two phases. An over-length detector latches the fault. A separate release timer, which runs only while transmit is idle, ends the fault. The fault state machine has three states:
- `ST_WATCH`: normal operation, timing any transmission.
- `ST_JABBER`: fault active, transmit still requested.
- `ST_UNJAB`: fault active, transmit idle, release timer running.

The transitions are:
- `WATCH→JABBER` (trip): a transmission hits the limit.
- `JABBER→UNJAB` (quiet): the transmit request is removed.
- `UNJAB→JABBER` (retry): transmit restarts before the release completes.
- `UNJAB→WATCH` (release): the quiet interval completes.

The tick length, the limit and the release interval are parameters. Typical settings are a limit between 20 and 150 ticks and a release between 250 and 750 ticks.

Top module: `tx_jabber_guard`

## Requirements
- R1: While reset is held and after it is released, `tx_drv_en` is 1, `jab_col` is 0 and `jab_flag` is 0.
- R2: A tick occurs in clock cycle c (counted from 0 at the first rising edge after reset release) exactly when c mod `TICK_CLKS` equals `TICK_CLKS`-1. In `ST_WATCH`, each tick that falls in a cycle with `tx_req` high adds one to the transmit-length count. A transmission trips on the tick that would make the count reach `LIMIT_TICKS`; shorter transmissions never trip.
- R3: In `ST_WATCH`, any cycle with `tx_req` low clears the transmit-length count. Two transmissions that are each under the limit therefore never trip, even if their combined length exceeds it.
- R4: On the trip edge, the block takes `WATCH→JABBER`. From that edge on, `tx_drv_en` is 0, `jab_col` is 1 and `jab_flag` is 1.
- R5: While in `ST_JABBER` with `tx_req` held high, the fault persists indefinitely.
- R6: The release timer advances only while in `ST_UNJAB` with `tx_req` low. On the edge of its `RELEASE_TICKS`-th tick, the block takes `UNJAB→WATCH`, `jab_col` returns to 0 and `tx_drv_en` returns to 1.
- R7: If `tx_req` rises while in `ST_UNJAB`, the block takes `UNJAB→JABBER` and the release timer clears. A later quiet period must again span a full `RELEASE_TICKS` ticks.
- R8: `jab_flag` is sticky. It stays set through the release and falls only on an edge where `flag_clr` is high. A trip on the same edge as a clear leaves the flag set. A clear while the flag is already 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Transmit data stream active |
| flag_clr | input | 1 | Clears the sticky jabber flag |
| tx_drv_en | output | 1 | Transmit driver enable |
| jab_col | output | 1 | Collision indication while jabbered |
| jab_flag | output | 1 | Sticky jabber status |

## Verification
The bench drives several kinds of transmission:
- Bursts shorter than the limit, which separate a correct limit from one that is too short.
- Back-to-back short bursts separated by a single idle cycle, which expose a length count that fails to clear.
- A held transmission that trips and then keeps going, which shows both the exact trip edge and that the fault cannot end while transmit is active.

After the trip, the bench checks the release behaviour:
- A short retry in the middle of the quiet interval, which distinguishes a release timer that restarts from one that merely pauses.
- Clear pulses sent while the flag is idle, after the release, and held across a second trip, which check stickiness and the rule that a trip wins over a clear.

// File: rtl/jab_pkg.sv
package jab_pkg;
    typedef enum logic [1:0] {
        ST_WATCH  = 2'd0,
        ST_JABBER = 2'd1,
        ST_UNJAB  = 2'd2
    } jab_state_t;
endpackage

// File: rtl/jab_tick_gen.sv
module jab_tick_gen #(
    parameter int TICK_CLKS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = $clog2(TICK_CLKS + 1);

    logic [PW-1:0] pcnt;

    assign tick = (pcnt == PW'(TICK_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PW'(1);
        end
    end
endmodule

// File: rtl/jab_span_counter.sv
module jab_span_counter #(
    parameter int TERM = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic at_last
);
    localparam int CW = $clog2(TERM + 1);

    logic [CW-1:0] cnt;

    assign at_last = (cnt == CW'(TERM - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (advance) begin
            cnt <= at_last ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/jab_fsm.sv
module jab_fsm
    import jab_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_req,
    input  logic       flag_clr,
    input  logic       trip,
    input  logic       rel_done,
    output jab_state_t state,
    output logic       tx_drv_en,
    output logic       jab_col,
    output logic       jab_flag
);
    jab_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WATCH:  if (trip) nxt = ST_JABBER;
            ST_JABBER: if (!tx_req) nxt = ST_UNJAB;
            ST_UNJAB: begin
                if (tx_req) begin
                    nxt = ST_JABBER;
                end else if (rel_done) begin
                    nxt = ST_WATCH;
                end
            end
            default:   nxt = ST_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WATCH;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_drv_en <= 1'b1;
            jab_col   <= 1'b0;
            jab_flag  <= 1'b0;
        end else begin
            tx_drv_en <= (nxt == ST_WATCH);
            jab_col   <= (nxt != ST_WATCH);
            if (state == ST_WATCH && trip) begin
                jab_flag <= 1'b1;
            end else if (flag_clr) begin
                jab_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard
    import jab_pkg::*;
#(
    parameter int TICK_CLKS     = 50000,
    parameter int LIMIT_TICKS   = 100,
    parameter int RELEASE_TICKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req,
    input  logic flag_clr,
    output logic tx_drv_en,
    output logic jab_col,
    output logic jab_flag
);
    logic       tick;
    logic       len_last;
    logic       rel_last;
    logic       trip;
    logic       rel_done;
    logic       len_run;
    logic       rel_run;
    jab_state_t state;

    jab_tick_gen #(.TICK_CLKS(TICK_CLKS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign len_run = (state == ST_WATCH) && tx_req;
    assign rel_run = (state == ST_UNJAB) && !tx_req;

    jab_span_counter #(.TERM(LIMIT_TICKS)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!len_run),
        .advance (tick),
        .at_last (len_last)
    );

    jab_span_counter #(.TERM(RELEASE_TICKS)) u_rel (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!rel_run),
        .advance (tick),
        .at_last (rel_last)
    );

    assign trip     = len_run && tick && len_last;
    assign rel_done = rel_run && tick && rel_last;

    jab_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_req    (tx_req),
        .flag_clr  (flag_clr),
        .trip      (trip),
        .rel_done  (rel_done),
        .state     (state),
        .tx_drv_en (tx_drv_en),
        .jab_col   (jab_col),
        .jab_flag  (jab_flag)
    );
endmodule

module tx_jabber_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_req,
    input logic flag_clr,
    input logic tx_drv_en,
    input logic jab_col,
    input logic jab_flag
);
    assert_trip_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_drv_en) |-> jab_flag);

    assert_hold_while_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (jab_col && tx_req) |=> jab_col);

    assert_release_after_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jab_col) |-> !$past(tx_req));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (jab_flag && !flag_clr) |=> jab_flag);

    assert_flag_rises_on_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jab_flag) |-> jab_col);
endmodule

bind tx_jabber_guard tx_jabber_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_req    (tx_req),
    .flag_clr  (flag_clr),
    .tx_drv_en (tx_drv_en),
    .jab_col   (jab_col),
    .jab_flag  (jab_flag)
);

// File: tb/sim_tx_jabber_guard.sv
module sim_tx_jabber_guard;
    localparam int CLK_PERIOD = 10;
    localparam int P   = 4;
    localparam int LIM = 5;
    localparam int REL = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_req = 1'b0;
    logic flag_clr = 1'b0;
    logic tx_drv_en, jab_col, jab_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [2:0] q_exp[$];
    string      q_tag[$];

    // reference model state (0 watch, 1 jabber, 2 unjab)
    int m_st = 0, m_len = 0, m_rel = 0, cyc = 0;
    bit m_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_jabber_guard #(.TICK_CLKS(P), .LIMIT_TICKS(LIM), .RELEASE_TICKS(REL)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .flag_clr(flag_clr),
        .tx_drv_en(tx_drv_en), .jab_col(jab_col), .jab_flag(jab_flag)
    );

    task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s {drv,col,flag} actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: one cycle with the given inputs; model the edge that ends it
    task automatic step(bit tx, bit clr, string tag);
        bit tick;
        bit tripped;
        tx_req   = tx;
        flag_clr = clr;
        tick     = ((cyc % P) == P - 1);
        tripped  = 1'b0;
        case (m_st)
            0: begin
                if (!tx) m_len = 0;
                else if (tick) begin
                    if (m_len + 1 >= LIM) begin
                        m_st = 1; m_len = 0; tripped = 1'b1;
                    end else m_len++;
                end
            end
            1: if (!tx) begin m_st = 2; m_rel = 0; end
            default: begin
                if (tx) begin m_st = 1; m_rel = 0; end
                else if (tick) begin
                    if (m_rel + 1 >= REL) begin m_st = 0; m_rel = 0; end
                    else m_rel++;
                end
            end
        endcase
        if (tripped) m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        q_exp.push_back({m_st == 0, m_st != 0, m_flag});
        q_tag.push_back(tag);
        cyc++;
        @(negedge clk);
    endtask

    task automatic run(bit tx, bit clr, int n, string tag);
        for (int i = 0; i < n; i++) step(tx, clr, tag);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (rst_n && q_exp.size() > 0) begin
            check(q_tag.pop_front(), {tx_drv_en, jab_col, jab_flag}, q_exp.pop_front());
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", {tx_drv_en, jab_col, jab_flag}, 3'b100);
        rst_n = 1'b1;
        check("R1 after release", {tx_drv_en, jab_col, jab_flag}, 3'b100);
        run(0, 0, 10, "R1 idle");
        run(1, 0, 12, "R2 short burst");
        run(0, 0, 5,  "R2 gap");
        run(1, 0, 14, "R3 burst a");
        run(0, 0, 1,  "R3 one idle");
        run(1, 0, 14, "R3 burst b");
        run(0, 0, 3,  "R3 gap");
        run(0, 1, 1,  "R8 clear while zero");
        run(0, 0, 2,  "R8 after idle clear");
        run(1, 0, 24, "R4 trip");
        run(1, 0, 30, "R5 hold");
        run(0, 0, 10, "R6 quiet part");
        run(1, 0, 3,  "R7 retry");
        run(0, 0, 10, "R7 restarted timer");
        run(0, 0, 20, "R6 release");
        run(0, 0, 5,  "R8 sticky");
        run(0, 1, 1,  "R8 clear");
        run(0, 0, 3,  "R8 cleared");
        run(1, 1, 25, "R8 trip beats clear");
        run(0, 0, 30, "R6 second release");
        run(1, 0, 20, "R2 limit exact");
        run(0, 0, 30, "R6 third release");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule